// File: doc/BRIEF.md
# Fabric Input Injection Controller with Single-Slot Retry Loop

This block sits between one packet source and one input of a slotted, bufferless switching fabric. In every slot it looks at three things: whether the source offers a new framed packet, whether its retry loop holds a packet from the previous slot, and whether the fabric reports its input as busy. From these alone it decides, within the same slot, which packet goes into the fabric, which one goes back into the loop, and which one, if any, is discarded. The source is never stalled.

The only storage is a loop register that holds one packet for exactly one slot. A packet that cannot enter is put into the loop and offered again in the next slot. This repeats for as many slots as the fabric stays busy, and each pass costs the same single register. When two packets compete, the older one in the loop wins. The newer one is either looped, if the fabric takes the older one, or dropped, if the fabric is busy. A one-slot drop strobe carries the dropped packet's tag. Three saturating counters record injections, loop writes and drops.

Top module: `inj_ctrl_top`

## Requirements
- R1: While reset is asserted and in the first slot after it, the loop is empty, `inj_valid` and `drop_pulse` are low, and all three counters read zero.
- R2: With a framed source packet, an empty loop and `fab_busy` low, the packet appears on `inj_tag`/`inj_data` with `inj_valid` high in that same slot.
- R3: With a framed source packet, an empty loop and `fab_busy` high, nothing is injected. The packet is written into the loop unchanged and is offered again in the next slot.
- R4: With a framed source packet, a loop packet and `fab_busy` low, the loop packet is injected and the source packet is written into the loop.
- R5: With a framed source packet, a loop packet and `fab_busy` high, the source packet is dropped: `drop_pulse` is high for that slot only, and `drop_tag` carries its tag. The loop packet stays in the loop.
- R6: A looped packet is offered again exactly one slot later. It can be looped any number of times in a row and keeps its tag and data each time.
- R7: `cnt_inj`, `cnt_recirc` and `cnt_drop` each rise by one in the slot after an injection, a loop write or a drop. Each stops at its maximum value (2^CNT_W-1) and never wraps.
- R8: When `src_frame` is low, `src_tag` and `src_data` are ignored. With an empty loop, nothing is injected, nothing is looped and nothing is dropped.
- R9: `inj_valid` is never high while `fab_busy` is high, and `drop_pulse` is never high unless both packets are present and `fab_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| src_frame | input | 1 | Source offers a packet this slot |
| src_tag | input | TAG_W | Identifier of the offered packet |
| src_data | input | DATA_W | Body of the offered packet |
| fab_busy | input | 1 | Fabric input cannot accept a packet this slot |
| inj_valid | output | 1 | A packet is injected this slot |
| inj_tag | output | TAG_W | Tag of the injected packet |
| inj_data | output | DATA_W | Body of the injected packet |
| drop_pulse | output | 1 | A packet is discarded this slot |
| drop_tag | output | TAG_W | Tag of the discarded packet |
| cnt_inj | output | CNT_W | Saturating count of injections |
| cnt_recirc | output | CNT_W | Saturating count of loop writes |
| cnt_drop | output | CNT_W | Saturating count of drops |

## Verification
A reference model in the bench replays the priority rules slot by slot, and every slot's expected injection and drop are compared against the design. The bench targets the two-packet cases. A design with the priority inverted would inject the new packet and trap the older one. A design that drops the wrong packet would report the loop packet's tag on `drop_tag`. Long busy stretches test that a looped packet returns exactly one slot later, intact, every time. A stale or shifted loop would reinject late or corrupt the data. Holding a packet for over 255 slots drives the loop counter into saturation, where a wrapping counter would read a small value.

// File: rtl/inj_pkg.sv
package inj_pkg;

    typedef struct packed {
        logic send_old;
        logic send_new;
        logic keep_old;
        logic keep_new;
        logic drop_new;
    } route_t;

    localparam int NUM_CNT = 3;
    localparam int CNT_INJ = 0;
    localparam int CNT_REC = 1;
    localparam int CNT_DRP = 2;

endpackage

// File: rtl/inj_arbiter.sv
module inj_arbiter
    import inj_pkg::*;
(
    input  logic   new_valid,
    input  logic   old_valid,
    input  logic   busy,
    output route_t route
);

    always_comb begin
        route = '0;
        unique case ({old_valid, new_valid})
            2'b11: begin
                route.send_old = !busy;
                route.keep_new = !busy;
                route.keep_old = busy;
                route.drop_new = busy;
            end
            2'b10: begin
                route.send_old = !busy;
                route.keep_old = busy;
            end
            2'b01: begin
                route.send_new = !busy;
                route.keep_new = busy;
            end
            default: route = '0;
        endcase
    end

endmodule

// File: rtl/inj_recirc_slot.sv
module inj_recirc_slot #(
    parameter int W = 38
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_new,
    input  logic         hold_old,
    input  logic [W-1:0] new_word,
    output logic         valid_q,
    output logic [W-1:0] word_q
);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] word;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (load_new) begin
            slot_d.valid = 1'b1;
            slot_d.word  = new_word;
        end else if (hold_old) begin
            slot_d.valid = 1'b1;
        end else begin
            slot_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign valid_q = slot_q.valid;
    assign word_q  = slot_q.word;

    // R6: a held word survives unchanged into the next slot
    a_r6_hold_intact: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_old && !load_new) |=> (valid_q && $stable(word_q)));

endmodule

// File: rtl/inj_sat_counter.sv
module inj_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (inc && count_q != MAXV) count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

    // R7: saturated counter stays put
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == MAXV) |=> (count_q == MAXV));
    // R7: counter never goes down
    a_r7_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count_q >= $past(count_q)));

endmodule

// File: rtl/inj_ctrl_top.sv
module inj_ctrl_top
    import inj_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_frame,
    input  logic [TAG_W-1:0]  src_tag,
    input  logic [DATA_W-1:0] src_data,
    input  logic              fab_busy,
    output logic              inj_valid,
    output logic [TAG_W-1:0]  inj_tag,
    output logic [DATA_W-1:0] inj_data,
    output logic              drop_pulse,
    output logic [TAG_W-1:0]  drop_tag,
    output logic [CNT_W-1:0]  cnt_inj,
    output logic [CNT_W-1:0]  cnt_recirc,
    output logic [CNT_W-1:0]  cnt_drop
);

    localparam int PKT_W = TAG_W + DATA_W;

    route_t           route;
    logic             loop_valid;
    logic [PKT_W-1:0] loop_word;
    logic [PKT_W-1:0] src_word;
    logic [PKT_W-1:0] out_word;
    logic [NUM_CNT-1:0]           cnt_inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;

    assign src_word = {src_tag, src_data};

    inj_arbiter u_arb (
        .new_valid (src_frame),
        .old_valid (loop_valid),
        .busy      (fab_busy),
        .route     (route)
    );

    inj_recirc_slot #(.W(PKT_W)) u_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_new (route.keep_new),
        .hold_old (route.keep_old),
        .new_word (src_word),
        .valid_q  (loop_valid),
        .word_q   (loop_word)
    );

    always_comb begin
        out_word = route.send_old ? loop_word : src_word;
    end

    assign inj_valid  = route.send_old | route.send_new;
    assign inj_tag    = inj_valid ? out_word[PKT_W-1:DATA_W] : '0;
    assign inj_data   = inj_valid ? out_word[DATA_W-1:0] : '0;
    assign drop_pulse = route.drop_new;
    assign drop_tag   = route.drop_new ? src_tag : '0;

    assign cnt_inc[CNT_INJ] = inj_valid;
    assign cnt_inc[CNT_REC] = route.keep_new | route.keep_old;
    assign cnt_inc[CNT_DRP] = route.drop_new;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        inj_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[g]),
            .count (cnt_val[g])
        );
    end

    assign cnt_inj    = cnt_val[CNT_INJ];
    assign cnt_recirc = cnt_val[CNT_REC];
    assign cnt_drop   = cnt_val[CNT_DRP];

    // R9: the fabric never receives a packet while busy
    a_r9_no_inject_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fab_busy |-> !inj_valid);
    // R9: drops only happen under two-packet contention with busy high
    a_r9_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> (src_frame && loop_valid && fab_busy));
    // R3: a lone blocked packet lands in the loop unchanged
    a_r3_blocked_loops: assert property (@(posedge clk) disable iff (!rst_n)
        (src_frame && !loop_valid && fab_busy) |=>
            (loop_valid && loop_word == $past(src_word)));
    // R4: the older packet wins when the fabric is free
    a_r4_old_first: assert property (@(posedge clk) disable iff (!rst_n)
        (src_frame && loop_valid && !fab_busy) |->
            (inj_valid && inj_tag == loop_word[PKT_W-1:DATA_W]));
    // R2: a lone packet with a free fabric goes straight in
    a_r2_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (src_frame && !loop_valid && !fab_busy) |->
            (inj_valid && inj_tag == src_tag && inj_data == src_data));
    // R8: with nothing offered, nothing moves
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_frame && !loop_valid) |=> (!loop_valid && !$past(inj_valid)));

endmodule

// File: tb/inj_ctrl_top_tb_top.sv
module inj_ctrl_top_tb_top;

    localparam int TAG_W  = 6;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam int MAXC   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              src_frame;
    logic [TAG_W-1:0]  src_tag;
    logic [DATA_W-1:0] src_data;
    logic              fab_busy;
    logic              inj_valid;
    logic [TAG_W-1:0]  inj_tag;
    logic [DATA_W-1:0] inj_data;
    logic              drop_pulse;
    logic [TAG_W-1:0]  drop_tag;
    logic [CNT_W-1:0]  cnt_inj, cnt_recirc, cnt_drop;

    always #2 clk = ~clk;

    inj_ctrl_top #(.TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_frame(src_frame), .src_tag(src_tag),
        .src_data(src_data), .fab_busy(fab_busy), .inj_valid(inj_valid),
        .inj_tag(inj_tag), .inj_data(inj_data), .drop_pulse(drop_pulse),
        .drop_tag(drop_tag), .cnt_inj(cnt_inj), .cnt_recirc(cnt_recirc),
        .cnt_drop(cnt_drop)
    );

    typedef struct {
        logic              inj_v;
        logic [TAG_W-1:0]  inj_t;
        logic [DATA_W-1:0] inj_d;
        logic              drp_v;
        logic [TAG_W-1:0]  drp_t;
        string             req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;

    logic              m_lv = 1'b0;
    logic [TAG_W-1:0]  m_lt = '0;
    logic [DATA_W-1:0] m_ld = '0;
    int m_inj = 0, m_rec = 0, m_drp = 0;

    task automatic chk(input string req, input string what, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic slot(input logic fr, input logic [TAG_W-1:0] t,
                        input logic [DATA_W-1:0] d, input logic b, input string req);
        exp_t e;
        @(negedge clk);
        src_frame = fr; src_tag = t; src_data = d; fab_busy = b;
        e.inj_v = 0; e.inj_t = '0; e.inj_d = '0; e.drp_v = 0; e.drp_t = '0; e.req = req;
        if (m_lv && fr) begin
            if (!b) begin
                e.inj_v = 1; e.inj_t = m_lt; e.inj_d = m_ld;
                m_lt = t; m_ld = d; m_rec++;
            end else begin
                e.drp_v = 1; e.drp_t = t; m_drp++; m_rec++;
            end
        end else if (m_lv) begin
            if (!b) begin
                e.inj_v = 1; e.inj_t = m_lt; e.inj_d = m_ld; m_lv = 0;
            end else m_rec++;
        end else if (fr) begin
            if (!b) begin
                e.inj_v = 1; e.inj_t = t; e.inj_d = d;
            end else begin
                m_lv = 1; m_lt = t; m_ld = d; m_rec++;
            end
        end
        if (e.inj_v) m_inj++;
        if (m_inj > MAXC) m_inj = MAXC;
        if (m_rec > MAXC) m_rec = MAXC;
        if (m_drp > MAXC) m_drp = MAXC;
        exp_q.push_back(e);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.req, "inj_valid", inj_valid, e.inj_v);
                if (e.inj_v) begin
                    chk(e.req, "inj_tag", inj_tag, e.inj_t);
                    chk(e.req, "inj_data", inj_data, e.inj_d);
                end
                chk(e.req, "drop_pulse", drop_pulse, e.drp_v);
                if (e.drp_v) chk(e.req, "drop_tag", drop_tag, e.drp_t);
            end
        end
    end

    task automatic check_counts(input string req);
        @(negedge clk);
        #1;
        chk(req, "cnt_inj", cnt_inj, m_inj);
        chk(req, "cnt_recirc", cnt_recirc, m_rec);
        chk(req, "cnt_drop", cnt_drop, m_drp);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; src_frame = 0; src_tag = '0; src_data = '0; fab_busy = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1 reset state
        chk("R1", "inj_valid", inj_valid, 0);
        chk("R1", "drop_pulse", drop_pulse, 0);
        chk("R1", "cnt_inj", cnt_inj, 0);
        chk("R1", "cnt_recirc", cnt_recirc, 0);
        chk("R1", "cnt_drop", cnt_drop, 0);
        @(negedge clk); rst_n = 1;

        // R8 unframed garbage is ignored, also while busy
        slot(0, 6'h3f, 32'hdeadbeef, 0, "R8");
        slot(0, 6'h2a, 32'h12345678, 1, "R8");
        slot(0, 6'h00, 32'h0, 0, "R8");
        check_counts("R8");

        // R2 direct injection, several patterns
        slot(1, 6'd1, 32'h0000_0001, 0, "R2");
        slot(1, 6'd2, 32'hffff_ffff, 0, "R2");
        slot(1, 6'd63, 32'ha5a5_5a5a, 0, "R2");

        // R3 blocked lone packet retried next slot
        slot(1, 6'd5, 32'hcafe_0005, 1, "R3");
        slot(0, 6'd0, 32'h0, 0, "R3");

        // R6 several consecutive retries
        slot(1, 6'd6, 32'h0600_0006, 1, "R6");
        slot(0, 6'd0, 32'h0, 1, "R6");
        slot(0, 6'd0, 32'h0, 1, "R6");
        slot(0, 6'd0, 32'h0, 0, "R6");
        check_counts("R7");

        // R4 contention with free fabric: older first, newer looped
        slot(1, 6'd10, 32'h0a0a_0a0a, 1, "R4");
        slot(1, 6'd11, 32'h0b0b_0b0b, 0, "R4");
        slot(1, 6'd12, 32'h0c0c_0c0c, 0, "R4");
        slot(0, 6'd0, 32'h0, 0, "R4");

        // R5 contention with busy fabric: newer dropped
        slot(1, 6'd20, 32'h1414_1414, 1, "R5");
        slot(1, 6'd21, 32'h1515_1515, 1, "R5");
        slot(1, 6'd22, 32'h1616_1616, 1, "R5");
        slot(0, 6'd0, 32'h0, 0, "R5");
        slot(0, 6'd0, 32'h0, 0, "R5");
        check_counts("R5");

        // R9 busy released mid-stream
        slot(1, 6'd30, 32'h1e1e_1e1e, 1, "R9");
        slot(1, 6'd31, 32'h1f1f_1f1f, 1, "R9");
        slot(1, 6'd32, 32'h2020_2020, 0, "R9");
        slot(0, 6'd0, 32'h0, 0, "R9");
        check_counts("R7");

        // R7 saturation of the loop counter
        slot(1, 6'd40, 32'h2828_2828, 1, "R7");
        for (int i = 0; i < 300; i++) slot(0, 6'd0, 32'h0, 1, "R6");
        slot(0, 6'd0, 32'h0, 0, "R6");
        check_counts("R7");
        chk("R7", "cnt_recirc saturated", cnt_recirc, MAXC);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule